// File: doc/BRIEF.md
# Ethernet PHY Management Register Responder

This block models the management register file of a single Ethernet PHY as seen from the MAC side. Software reaches it through two 32-bit words: a command word and a data word. A write to the command word can carry a read or write request for one of 32 PHY register numbers. A read request loads the 16-bit register value into the upper half of the data word. A write request takes its value from the lower half of the data word. The bit that requested the access clears itself in the command word once the access is done.

The block holds control, status, advertisement, interrupt-source and interrupt-mask registers. Each has a fixed reset value and a write mask. Identification and partner-ability registers read as constants. Starting auto-negotiation completes at once. An external link-up level is copied into the status register and raises interrupt-source bits whenever it changes, and also right after any reset. The interrupt-source register clears when it is read. The block drives a registered PHY interrupt request, which is the OR over the source bits that are also enabled in the mask.

Top module: `mii_phy_regfile`

## Requirements
- R1: After reset, PHY register 0 (control) reads 0x3000, register 4 (advertisement) reads 0x01E1 and register 30 (interrupt mask) reads 0. Register 1 (status) has base value 0x7809, and register 29 (interrupt source) starts at 0. The link state is applied in the first clock after reset, so with the link up, status reads 0x782D and the source reads 0x00C0.
- R2: Whenever the applied link level changes, status bits 5 and 2 follow it. Link up sets both bits and ORs 0x00C0 into the interrupt source. Link down clears both bits and ORs 0x0010 into the interrupt source.
- R3: A write to register 0 with bit 15 set restores every PHY register to its reset value, and the link is applied again in the following cycle. Any other write to register 0 stores value & 0x7980, and if value bit 12 is set it also sets status bit 5.
- R4: A write to register 4 stores (value & 0x2D7F) | 0x0080.
- R5: A write to register 30 stores value & 0x00FF.
- R6: These registers read as constants: register 2 reads 0x0007, register 3 reads 0xC0D1, register 5 reads 0x0F71 and register 6 reads 0x0001. Writes to them have no effect.
- R7: A read of register 29 returns the current interrupt source and then clears it. If a link event happens in the same cycle, the bits it sets are kept.
- R8: In the command word, the register number is bits 25:21, the read request is bit 26 and the write request is bit 27. After a read, the data word holds the value in bits 31:16, with bits 15:0 equal to zero. A write takes only data-word bits 15:0. A direct data-word write stores all 32 bits. If a read completes in the same cycle as a direct data-word write, the read result wins.
- R9: The command word keeps the written value except for the request bit that was served. The write request (bit 27) takes priority and is cleared; otherwise a read request (bit 26) is cleared.
- R10: Register numbers 7 to 28 and 31 read as zero and ignore writes.
- R11: The interrupt output goes high one clock after the interrupt source and mask share a set bit, and goes low one clock after they no longer do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Write strobe for the command word |
| cmd_wdata_i | input | 32 | Command word value |
| data_we_i | input | 1 | Write strobe for the data word |
| data_wdata_i | input | 32 | Data word value |
| link_up_i | input | 1 | Current link level from the line side |
| cmd_o | output | 32 | Command word contents |
| data_o | output | 32 | Data word contents |
| phy_irq_o | output | 1 | Registered PHY interrupt request |

## Verification
Each writable register receives both an all-zero and an all-ones pattern, plus mixed values. Together these separate the forced bits from the masked bits, so an error in either the AND mask or the OR constant shows up. Link transitions in both directions, combined with back-to-back reads of the interrupt source, show whether bits are set by the correct edge and whether the clear-on-read happens. Mask settings that do and do not cover the raised source bits, sampled cycle by cycle, pin down the one-clock lag of the interrupt. Writes to constant and unknown register numbers, a data word whose upper and lower halves differ, and a soft reset through the control register confirm that the intended path alone changes state.

// File: rtl/mii_phy_pkg.sv
package mii_phy_pkg;
  localparam int unsigned PHY_DW = 16;
  localparam int unsigned REG_AW = 5;

  localparam logic [REG_AW-1:0] RA_CTRL = 5'd0;
  localparam logic [REG_AW-1:0] RA_STAT = 5'd1;
  localparam logic [REG_AW-1:0] RA_ID_HI = 5'd2;
  localparam logic [REG_AW-1:0] RA_ID_LO = 5'd3;
  localparam logic [REG_AW-1:0] RA_ADV = 5'd4;
  localparam logic [REG_AW-1:0] RA_LPA = 5'd5;
  localparam logic [REG_AW-1:0] RA_EXP = 5'd6;
  localparam logic [REG_AW-1:0] RA_ISRC = 5'd29;
  localparam logic [REG_AW-1:0] RA_IMSK = 5'd30;

  localparam logic [PHY_DW-1:0] CTRL_RST = 16'h3000;
  localparam logic [PHY_DW-1:0] STAT_RST = 16'h7809;
  localparam logic [PHY_DW-1:0] ADV_RST = 16'h01E1;
  localparam logic [PHY_DW-1:0] CTRL_WMASK = 16'h7980;
  localparam logic [PHY_DW-1:0] ADV_WMASK = 16'h2D7F;
  localparam logic [PHY_DW-1:0] ADV_FORCE = 16'h0080;
  localparam logic [PHY_DW-1:0] IMSK_WMASK = 16'h00FF;
  localparam logic [PHY_DW-1:0] STAT_LINK = 16'h0024;
  localparam logic [PHY_DW-1:0] STAT_ANEG = 16'h0020;
  localparam logic [PHY_DW-1:0] ISRC_UP = 16'h00C0;
  localparam logic [PHY_DW-1:0] ISRC_DOWN = 16'h0010;

  localparam logic [PHY_DW-1:0] ID_HI_VAL = 16'h0007;
  localparam logic [PHY_DW-1:0] ID_LO_VAL = 16'hC0D1;
  localparam logic [PHY_DW-1:0] LPA_VAL = 16'h0F71;
  localparam logic [PHY_DW-1:0] EXP_VAL = 16'h0001;

  localparam int unsigned CTRL_SRST_BIT = 15;
  localparam int unsigned CTRL_ANEG_BIT = 12;
endpackage

// File: rtl/mii_phy_cmd_dec.sv
module mii_phy_cmd_dec
  import mii_phy_pkg::*;
#(
  parameter int unsigned CMD_W = 32,
  parameter int unsigned ADDR_LSB = 21,
  parameter int unsigned RD_BIT = 26,
  parameter int unsigned WR_BIT = 27
) (
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic [REG_AW-1:0] addr_o
);
  // write request wins when both are set
  assign wr_en_o = cmd_we_i & cmd_i[WR_BIT];
  assign rd_en_o = cmd_we_i & cmd_i[RD_BIT] & ~cmd_i[WR_BIT];
  assign addr_o  = cmd_i[ADDR_LSB +: REG_AW];
endmodule

// File: rtl/mii_phy_reg_bank.sv
module mii_phy_reg_bank
  import mii_phy_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [PHY_DW-1:0] wdata_i,
  input  logic              link_up_i,
  output logic [PHY_DW-1:0] rdata_o,
  output logic [PHY_DW-1:0] isrc_o,
  output logic [PHY_DW-1:0] imsk_o
);
  logic [PHY_DW-1:0] ctrl_q, stat_q, adv_q, isrc_q, imsk_q;
  logic [PHY_DW-1:0] ctrl_d, stat_d, adv_d, isrc_d, imsk_d;
  logic              init_q, init_d, link_q, link_d;
  logic              soft_rst, link_evt;

  assign soft_rst = wr_en_i && addr_i == RA_CTRL && wdata_i[CTRL_SRST_BIT];
  assign link_evt = !soft_rst && (!init_q || link_up_i != link_q);

  always_comb begin
    ctrl_d = ctrl_q;
    stat_d = stat_q;
    adv_d  = adv_q;
    isrc_d = isrc_q;
    imsk_d = imsk_q;
    init_d = init_q;
    link_d = link_q;
    if (soft_rst) begin
      ctrl_d = CTRL_RST;
      stat_d = STAT_RST;
      adv_d  = ADV_RST;
      isrc_d = '0;
      imsk_d = '0;
      init_d = 1'b0;
      link_d = 1'b0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        RA_CTRL: begin
          ctrl_d = wdata_i & CTRL_WMASK;
          if (wdata_i[CTRL_ANEG_BIT]) stat_d = stat_d | STAT_ANEG;
        end
        RA_ADV:  adv_d  = (wdata_i & ADV_WMASK) | ADV_FORCE;
        RA_IMSK: imsk_d = wdata_i & IMSK_WMASK;
        default: ;
      endcase
    end
    if (rd_en_i && addr_i == RA_ISRC) isrc_d = '0;
    // link event is applied last so its source bits survive a same-cycle clear
    if (link_evt) begin
      init_d = 1'b1;
      link_d = link_up_i;
      if (link_up_i) begin
        stat_d = stat_d | STAT_LINK;
        isrc_d = isrc_d | ISRC_UP;
      end else begin
        stat_d = stat_d & ~STAT_LINK;
        isrc_d = isrc_d | ISRC_DOWN;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      stat_q <= STAT_RST;
      adv_q  <= ADV_RST;
      isrc_q <= '0;
      imsk_q <= '0;
      init_q <= 1'b0;
      link_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      adv_q  <= adv_d;
      isrc_q <= isrc_d;
      imsk_q <= imsk_d;
      init_q <= init_d;
      link_q <= link_d;
    end
  end

  always_comb begin
    unique case (addr_i)
      RA_CTRL:  rdata_o = ctrl_q;
      RA_STAT:  rdata_o = stat_q;
      RA_ID_HI: rdata_o = ID_HI_VAL;
      RA_ID_LO: rdata_o = ID_LO_VAL;
      RA_ADV:   rdata_o = adv_q;
      RA_LPA:   rdata_o = LPA_VAL;
      RA_EXP:   rdata_o = EXP_VAL;
      RA_ISRC:  rdata_o = isrc_q;
      RA_IMSK:  rdata_o = imsk_q;
      default:  rdata_o = '0;
    endcase
  end

  assign isrc_o = isrc_q;
  assign imsk_o = imsk_q;

  AST_LINK_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && link_q) |-> (stat_q[2] && stat_q[5])); // R2
  AST_ISRC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == RA_ISRC && !link_evt) |=> (isrc_q == '0)); // R7
  AST_CTRL_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q & ~CTRL_WMASK) == '0); // R3
  AST_ADV_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == RA_ADV) |=> adv_q[7]); // R4
endmodule

// File: rtl/mii_phy_irq_gen.sv
module mii_phy_irq_gen
  import mii_phy_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PHY_DW-1:0] isrc_i,
  input  logic [PHY_DW-1:0] imsk_i,
  output logic              irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(isrc_i & imsk_i);
  end

  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(isrc_i & imsk_i)) |=> irq_o); // R11
  AST_IRQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(isrc_i & imsk_i)) |=> !irq_o); // R11
endmodule

// File: rtl/mii_phy_regfile.sv
module mii_phy_regfile
  import mii_phy_pkg::*;
#(
  parameter int unsigned CMD_W = 32,
  parameter int unsigned ADDR_LSB = 21,
  parameter int unsigned RD_BIT = 26,
  parameter int unsigned WR_BIT = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  input  logic             data_we_i,
  input  logic [CMD_W-1:0] data_wdata_i,
  input  logic             link_up_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic [CMD_W-1:0] data_o,
  output logic             phy_irq_o
);
  localparam int unsigned PAD_W = CMD_W - PHY_DW;

  logic              rd_en, wr_en;
  logic [REG_AW-1:0] addr;
  logic [PHY_DW-1:0] rdata, isrc, imsk;
  logic [CMD_W-1:0]  cmd_q, data_q;

  mii_phy_cmd_dec #(
    .CMD_W(CMD_W), .ADDR_LSB(ADDR_LSB), .RD_BIT(RD_BIT), .WR_BIT(WR_BIT)
  ) u_dec (
    .cmd_we_i(cmd_we_i), .cmd_i(cmd_wdata_i),
    .rd_en_o(rd_en), .wr_en_o(wr_en), .addr_o(addr)
  );

  mii_phy_reg_bank u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(data_q[PHY_DW-1:0]), .link_up_i(link_up_i),
    .rdata_o(rdata), .isrc_o(isrc), .imsk_o(imsk)
  );

  mii_phy_irq_gen u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .isrc_i(isrc), .imsk_i(imsk), .irq_o(phy_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (cmd_we_i) begin
        cmd_q <= cmd_wdata_i;
        if (wr_en)      cmd_q[WR_BIT] <= 1'b0;
        else if (rd_en) cmd_q[RD_BIT] <= 1'b0;
      end
      if (rd_en)          data_q <= {rdata, {PAD_W{1'b0}}};
      else if (data_we_i) data_q <= data_wdata_i;
    end
  end

  assign cmd_o  = cmd_q;
  assign data_o = data_q;

  AST_WR_STROBE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_wdata_i[WR_BIT]) |=> !cmd_o[WR_BIT]); // R9
  AST_RD_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |=> (data_o[PAD_W-1:0] == '0)); // R8
endmodule

// File: tb/mii_phy_regfile_tb_top.sv
module mii_phy_regfile_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_we_i = 1'b0;
  logic [31:0] cmd_wdata_i = '0;
  logic        data_we_i = 1'b0;
  logic [31:0] data_wdata_i = '0;
  logic        link_up_i = 1'b1;
  logic [31:0] cmd_o, data_o;
  logic        phy_irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  mii_phy_regfile dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_we_i(cmd_we_i), .cmd_wdata_i(cmd_wdata_i),
    .data_we_i(data_we_i), .data_wdata_i(data_wdata_i),
    .link_up_i(link_up_i),
    .cmd_o(cmd_o), .data_o(data_o), .phy_irq_o(phy_irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic phy_rd(input logic [4:0] ra, output logic [15:0] val);
    @(negedge clk_i);
    cmd_we_i = 1'b1;
    cmd_wdata_i = (32'd1 << 26) | (32'(ra) << 21);
    @(negedge clk_i);
    cmd_we_i = 1'b0;
    val = data_o[31:16];
  endtask

  task automatic phy_wr(input logic [4:0] ra, input logic [31:0] dw);
    @(negedge clk_i);
    data_we_i = 1'b1;
    data_wdata_i = dw;
    @(negedge clk_i);
    data_we_i = 1'b0;
    cmd_we_i = 1'b1;
    cmd_wdata_i = (32'd1 << 27) | (32'(ra) << 21);
    @(negedge clk_i);
    cmd_we_i = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [4:0] ra, input logic [15:0] exp);
    logic [15:0] v;
    phy_rd(ra, v);
    check(req, {16'h0, v}, {16'h0, exp});
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    check("R1 irq", {31'h0, phy_irq_o}, 32'h0);
    check("R1 cmd", cmd_o, 32'h0);
    check("R1 data", data_o, 32'h0);
    expect_reg("R1 ctrl", 5'd0, 16'h3000);
    expect_reg("R1 stat", 5'd1, 16'h782D);
    expect_reg("R1 adv", 5'd4, 16'h01E1);
    expect_reg("R1 mask", 5'd30, 16'h0000);
    expect_reg("R1 isrc", 5'd29, 16'h00C0);
    expect_reg("R7 isrc cleared", 5'd29, 16'h0000);
  endtask

  task automatic t_consts;
    expect_reg("R6 id hi", 5'd2, 16'h0007);
    check("R8 low half zero", {16'h0, data_o[15:0]}, 32'h0);
    expect_reg("R6 id lo", 5'd3, 16'hC0D1);
    expect_reg("R6 lpa", 5'd5, 16'h0F71);
    expect_reg("R6 exp", 5'd6, 16'h0001);
    phy_wr(5'd2, 32'h0000_1234);
    expect_reg("R6 write ignored", 5'd2, 16'h0007);
  endtask

  task automatic t_strobe;
    logic [31:0] c;
    c = (32'd1 << 26) | (32'd3 << 21) | 32'h0000_0101;
    @(negedge clk_i);
    cmd_we_i = 1'b1; cmd_wdata_i = c;
    @(negedge clk_i);
    cmd_we_i = 1'b0;
    check("R9 read strobe clear", cmd_o, c & ~(32'd1 << 26));
    check("R8 read field", data_o, 32'hC0D1_0000);
    c = (32'd1 << 27) | (32'd1 << 26) | (32'd7 << 21);
    @(negedge clk_i);
    cmd_we_i = 1'b1; cmd_wdata_i = c;
    @(negedge clk_i);
    cmd_we_i = 1'b0;
    check("R9 write strobe clear", cmd_o, c & ~(32'd1 << 27));
  endtask

  task automatic t_link_ctrl;
    @(negedge clk_i); link_up_i = 1'b0;
    @(negedge clk_i);
    expect_reg("R2 stat down", 5'd1, 16'h7809);
    expect_reg("R2 isrc down", 5'd29, 16'h0010);
    phy_wr(5'd0, 32'h0000_1000);
    expect_reg("R3 ctrl aneg", 5'd0, 16'h1000);
    expect_reg("R3 stat aneg", 5'd1, 16'h7829);
    phy_wr(5'd0, 32'h0000_7FFF);
    expect_reg("R3 ctrl mask", 5'd0, 16'h7980);
    @(negedge clk_i); link_up_i = 1'b1;
    @(negedge clk_i);
    expect_reg("R2 stat up", 5'd1, 16'h782D);
    expect_reg("R2 isrc up", 5'd29, 16'h00C0);
  endtask

  task automatic t_adv_mask;
    phy_wr(5'd4, 32'h0000_0000);
    expect_reg("R4 adv zero", 5'd4, 16'h0080);
    phy_wr(5'd4, 32'h0000_FFFF);
    expect_reg("R4 adv ones", 5'd4, 16'h2DFF);
    phy_wr(5'd30, 32'h0000_1234);
    expect_reg("R5 mask", 5'd30, 16'h0034);
    phy_wr(5'd30, 32'h5555_0000);
    expect_reg("R8 upper half unused", 5'd30, 16'h0000);
    @(negedge clk_i);
    data_we_i = 1'b1; data_wdata_i = 32'hABCD_1234;
    @(negedge clk_i);
    data_we_i = 1'b0;
    check("R8 data write", data_o, 32'hABCD_1234);
  endtask

  task automatic t_unknown;
    phy_wr(5'd7, 32'h0000_BEEF);
    expect_reg("R10 reg7", 5'd7, 16'h0000);
    expect_reg("R10 reg31", 5'd31, 16'h0000);
    expect_reg("R10 reg28", 5'd28, 16'h0000);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    phy_wr(5'd30, 32'h0000_0010);
    check("R11 idle", {31'h0, phy_irq_o}, 32'h0);
    @(negedge clk_i); link_up_i = 1'b0;
    @(negedge clk_i);
    check("R11 lag", {31'h0, phy_irq_o}, 32'h0);
    @(negedge clk_i);
    check("R11 rise", {31'h0, phy_irq_o}, 32'h1);
    phy_rd(5'd29, v);
    check("R7 isrc read", {16'h0, v}, 32'h0010);
    check("R11 still high", {31'h0, phy_irq_o}, 32'h1);
    @(negedge clk_i);
    check("R11 fall", {31'h0, phy_irq_o}, 32'h0);
    @(negedge clk_i); link_up_i = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    check("R11 masked", {31'h0, phy_irq_o}, 32'h0);
    expect_reg("R2 isrc masked up", 5'd29, 16'h00C0);
  endtask

  task automatic t_soft_reset;
    phy_wr(5'd4, 32'h0000_0000);
    phy_wr(5'd30, 32'h0000_00FF);
    phy_wr(5'd0, 32'h0000_8000);
    expect_reg("R3 srst ctrl", 5'd0, 16'h3000);
    expect_reg("R3 srst adv", 5'd4, 16'h01E1);
    expect_reg("R3 srst mask", 5'd30, 16'h0000);
    expect_reg("R3 srst stat", 5'd1, 16'h782D);
    expect_reg("R3 srst isrc", 5'd29, 16'h00C0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_consts();
    t_strobe();
    t_link_ctrl();
    t_adv_mask();
    t_unknown();
    t_irq();
    t_soft_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule